// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, every cycle, which hardware thread the instruction fetch stage serves. Each thread reports two things. The first is a fetch status code. The second is a bit in an active mask. A thread may be picked only when it is active and its status shows that it can accept new instructions.

A static policy input chooses how eligible threads are ranked:
- A fixed thread 0.
- A rotating priority order, where the thread that was served moves to the back.
- The fullest instruction queue first.
- The fullest load/store queue first.

The choice is combinational. The grant reflects the inputs of the same cycle. The only stored state is the rotating order. That order changes on a clock edge only when the fetch stage consumes a grant that the rotating policy made.

The thread count is a parameter, from 1 to 4. With a single thread configured, the policy input has no effect.

Top module: `smt_fetch_pick`

## Requirements
- R1: After reset the rotating order is 0, 1, 2, 3. With all threads eligible under the rotating policy and no grant consumed, thread 0 is granted.
- R2: A thread is eligible only when its mask bit is 1 and its 3-bit status is 0 (running), 1 (line fill done) or 2 (idle). Codes 3 to 7 make it ineligible. Under policies 1 to 3, an ineligible thread is never granted.
- R3: When no thread qualifies, `grant_vld` is 0 and `grant_id` is 0. An inactive thread is never granted under any policy.
- R4: Under policy 1 (rotating), the grant goes to the first eligible thread found when scanning the order from its head.
- R5: When `pick_take` is 1 in a cycle where a policy-1 grant is valid, the next edge removes the granted thread from its position and appends it at the tail. In every other cycle the order keeps its value.
- R6: With more than one thread and policy 0, thread 0 is granted whenever it is active, whatever its status.
- R7: Under policy 2, the grant goes to the eligible thread with the largest instruction-queue count. A tie goes to the lower thread ID.
- R8: Under policy 3, the grant goes to the eligible thread with the largest load/store-queue count. A tie goes to the lower thread ID.
- R9: Policy 4 (branch count, not built) and codes 5 to 7 give no grant.
- R10: With one thread configured, the policy is ignored. Thread 0 is granted exactly when it is eligible.
- R11: The grant depends only on the current inputs and the stored order, with no cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 3 | Selection policy code |
| thr_active | input | THREADS | Per-thread active mask |
| thr_status | input | 3*THREADS | Per-thread status code, thread i at bits [3i+2:3i] |
| iq_cnt | input | CNT_W*THREADS | Per-thread instruction-queue occupancy |
| lsq_cnt | input | CNT_W*THREADS | Per-thread load/store-queue occupancy |
| pick_take | input | 1 | Fetch consumes this cycle's grant |
| grant_vld | output | 1 | A thread is granted |
| grant_id | output | IDW | Granted thread ID |

## Verification
The grant is due in the same cycle as its inputs. The bench drives inputs just after a rising edge and compares the outputs a few nanoseconds later, before the next edge. The effect of a consumed rotating grant first appears after the following rising edge. The reference model therefore updates its queue-based order right after that cycle's comparison, so it is ready for the next one. A 4-thread instance and a 1-thread instance are compared against the model on every cycle, under directed and random stimulus.

// File: rtl/smt_fetch_pick.sv
module smt_fetch_pick #(
  parameter int THREADS = 4,
  parameter int CNT_W   = 6,
  localparam int IDW    = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               policy,
  input  logic [THREADS-1:0]       thr_active,
  input  logic [3*THREADS-1:0]     thr_status,
  input  logic [CNT_W*THREADS-1:0] iq_cnt,
  input  logic [CNT_W*THREADS-1:0] lsq_cnt,
  input  logic                     pick_take,
  output logic                     grant_vld,
  output logic [IDW-1:0]           grant_id
);
  localparam logic [2:0] POL_FIXED = 3'd0;
  localparam logic [2:0] POL_ROT   = 3'd1;
  localparam logic [2:0] POL_IQ    = 3'd2;
  localparam logic [2:0] POL_LSQ   = 3'd3;

  logic [THREADS-1:0]     elig;
  logic [IDW*THREADS-1:0] ord_q, ord_nx;
  logic                   rr_vld, cnt_vld;
  logic [IDW-1:0]         rr_pos, rr_id, cnt_id;
  logic [CNT_W*THREADS-1:0] cnt_sel;
  logic                   move;

  always_comb begin
    for (int i = 0; i < THREADS; i++)
      elig[i] = thr_active[i] && (thr_status[3*i +: 3] < 3'd3);
  end

  always_comb begin
    rr_vld = 1'b0;
    rr_pos = '0;
    rr_id  = '0;
    for (int p = 0; p < THREADS; p++) begin
      if (!rr_vld && elig[ord_q[p*IDW +: IDW]]) begin
        rr_vld = 1'b1;
        rr_pos = IDW'(p);
        rr_id  = ord_q[p*IDW +: IDW];
      end
    end
  end

  assign cnt_sel = (policy == POL_LSQ) ? lsq_cnt : iq_cnt;

  always_comb begin
    logic [CNT_W-1:0] best;
    cnt_vld = 1'b0;
    cnt_id  = '0;
    best    = '0;
    for (int i = 0; i < THREADS; i++) begin
      if (elig[i] && (!cnt_vld || cnt_sel[i*CNT_W +: CNT_W] > best)) begin
        cnt_vld = 1'b1;
        cnt_id  = IDW'(i);
        best    = cnt_sel[i*CNT_W +: CNT_W];
      end
    end
  end

  generate
    if (THREADS == 1) begin : g_one
      assign grant_vld = elig[0];
      assign grant_id  = '0;
    end else begin : g_many
      always_comb begin
        grant_vld = 1'b0;
        grant_id  = '0;
        case (policy)
          POL_FIXED: grant_vld = thr_active[0];
          POL_ROT:   begin grant_vld = rr_vld;  grant_id = rr_id;  end
          POL_IQ,
          POL_LSQ:   begin grant_vld = cnt_vld; grant_id = cnt_id; end
          default:   ;
        endcase
      end
    end
  endgenerate

  assign move = (THREADS > 1) && pick_take && rr_vld && (policy == POL_ROT);

  always_comb begin
    for (int p = 0; p < THREADS; p++) begin
      if (p < int'(rr_pos))      ord_nx[p*IDW +: IDW] = ord_q[p*IDW +: IDW];
      else if (p < THREADS - 1)  ord_nx[p*IDW +: IDW] = ord_q[(p+1)*IDW +: IDW];
      else                       ord_nx[p*IDW +: IDW] = rr_id;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < THREADS; i++) ord_q[i*IDW +: IDW] <= IDW'(i);
    end else if (move) begin
      ord_q <= ord_nx;
    end
  end
endmodule

// File: rtl/smt_fetch_pick_chk.sv
module smt_fetch_pick_chk #(
  parameter int THREADS = 4,
  parameter int CNT_W   = 6,
  parameter int IDW     = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [2:0]               policy,
  input logic [THREADS-1:0]       thr_active,
  input logic [3*THREADS-1:0]     thr_status,
  input logic                     pick_take,
  input logic                     grant_vld,
  input logic [IDW-1:0]           grant_id,
  input logic [IDW*THREADS-1:0]   ord_q
);
  logic moved;
  assign moved = (THREADS > 1) && pick_take && grant_vld && (policy == 3'd1);

  a_r2_status_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && (THREADS == 1 || policy != 3'd0)) |-> (thr_status[grant_id*3 +: 3] < 3'd3));
  a_r3_active_only: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> thr_active[grant_id]);
  a_r3_zero_id: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_vld |-> (grant_id == '0));
  a_r9_bad_policy: assert property (@(posedge clk) disable iff (!rst_n)
    (THREADS > 1 && policy > 3'd3) |-> !grant_vld);
  a_r6_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (THREADS > 1 && policy == 3'd0 && thr_active[0]) |-> (grant_vld && grant_id == '0));
  a_r5_order_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !moved |=> $stable(ord_q));
  a_r5_tail: assert property (@(posedge clk) disable iff (!rst_n)
    moved |=> (ord_q[(THREADS-1)*IDW +: IDW] == $past(grant_id)));
endmodule

bind smt_fetch_pick smt_fetch_pick_chk #(.THREADS(THREADS), .CNT_W(CNT_W), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .policy(policy), .thr_active(thr_active),
  .thr_status(thr_status), .pick_take(pick_take), .grant_vld(grant_vld),
  .grant_id(grant_id), .ord_q(ord_q));

// File: tb/smt_fetch_pick_test.sv
module smt_fetch_pick_test;
  localparam int N = 4, CW = 6;
  logic clk = 0, rst_n = 0;
  logic [2:0] pol = 0;
  logic [N-1:0] act = 0;
  logic [3*N-1:0] st = 0;
  logic [CW*N-1:0] iq = 0, lsq = 0;
  logic take = 0;
  logic gv, gv1;
  logic [1:0] gid;
  logic [0:0] gid1;
  int checks = 0, fails = 0;
  int order[$];

  always #5 clk = ~clk;

  smt_fetch_pick #(.THREADS(N), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .policy(pol), .thr_active(act), .thr_status(st),
    .iq_cnt(iq), .lsq_cnt(lsq), .pick_take(take), .grant_vld(gv), .grant_id(gid));

  smt_fetch_pick #(.THREADS(1), .CNT_W(CW)) uut1 (
    .clk(clk), .rst_n(rst_n), .policy(pol), .thr_active(act[0:0]), .thr_status(st[2:0]),
    .iq_cnt(iq[CW-1:0]), .lsq_cnt(lsq[CW-1:0]), .pick_take(take), .grant_vld(gv1), .grant_id(gid1));

  function automatic bit ok(int i);
    return act[i] && (st[3*i +: 3] < 3);
  endfunction

  task automatic chk(string tag, logic av, int aid, logic ev, int eid);
    checks++;
    if (av !== ev || (ev && aid != eid) || (!ev && aid != 0)) begin
      fails++;
      $display("FAIL %s: got vld=%0b id=%0d, expected vld=%0b id=%0d", tag, av, aid, ev, eid);
    end
  endtask

  // Every compare is taken in the same cycle as its inputs (R11).
  task automatic cyc(string dtag);
    bit ev; int eid, pos; string tag;
    #2;
    ev = 0; eid = 0; pos = 0;
    case (pol)
      3'd0: begin ev = act[0]; tag = "R6"; end
      3'd1: begin
        tag = "R4";
        foreach (order[k]) if (!ev && ok(order[k])) begin ev = 1; eid = order[k]; pos = k; end
      end
      3'd2, 3'd3: begin
        int best; best = -1;
        tag = (pol == 3'd2) ? "R7" : "R8";
        for (int i = 0; i < N; i++) begin
          int c; c = (pol == 3'd2) ? int'(iq[i*CW +: CW]) : int'(lsq[i*CW +: CW]);
          if (ok(i) && c > best) begin best = c; ev = 1; eid = i; end
        end
      end
      default: tag = "R9";
    endcase
    if (!ev && pol inside {[1:3]}) tag = "R3";
    if (dtag != "") tag = dtag;
    chk(tag, gv, int'(gid), ev, eid);
    chk("R10", gv1, int'(gid1), ok(0), 0);
    if (pol == 3'd1 && take && ev) begin order.delete(pos); order.push_back(eid); end
    @(posedge clk); #1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) order.push_back(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    act = 4'hF; st = 0; pol = 3'd1; take = 0;
    cyc("R1");
    cyc("R1");
    take = 1;
    repeat (5) cyc("R5");
    take = 0; st = {3'd0, 3'd0, 3'd0, 3'd3};
    repeat (2) cyc("R5");
    st = {3'd7, 3'd5, 3'd4, 3'd3};
    cyc("R2");
    st = {3'd2, 3'd6, 3'd1, 3'd4}; take = 1;
    repeat (3) cyc("R2");
    act = 4'b0101; st = 0; take = 0;
    cyc("R3");
    pol = 3'd2; act = 4'hF; iq = {6'd9, 6'd20, 6'd20, 6'd3};
    cyc("R7");
    st[3*1 +: 3] = 3'd5;
    cyc("R7");
    pol = 3'd3; lsq = {6'd40, 6'd2, 6'd40, 6'd1};
    cyc("R8");
    act[1] = 0;
    cyc("R8");
    pol = 3'd0; st[2:0] = 3'd6;
    cyc("R6");
    act[0] = 0;
    cyc("R6");
    for (int p = 4; p < 8; p++) begin pol = 3'(p); act = 4'hF; st = 0; cyc("R9"); end
    for (int n = 0; n < 400; n++) begin
      pol  = ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 4);
      act  = 4'($urandom);
      for (int i = 0; i < N; i++) st[3*i +: 3] = ($urandom % 2) ? 3'($urandom % 3) : 3'($urandom);
      iq   = CW*N'($urandom % 4 == 0 ? 0 : $urandom);
      lsq  = CW*N'($urandom);
      take = 1'($urandom);
      cyc("");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule